// File: doc/BRIEF.md
# Alarm-Started Periodic Pulse Generator

This block watches a 64-bit nanosecond time counter and holds a 64-bit alarm time. The first time the counter, sampled on an increment strobe, is equal to or past the alarm, the block raises a one-clock alarm event. If the run-enable bit is set, that same moment starts up to three periodic pulse channels. Each channel begins in phase with the alarm, so its pulses fall on a chosen time-of-day boundary instead of free-running from reset. Channel 0 is normally programmed as the once-per-second pulse.

Software writes the alarm as two 32-bit words. The usual value is the next whole second at least half a second away, minus one step. Each channel's period register holds the wanted period minus one step. The step is the number of nanoseconds the time counter advances per strobe, and it is kept in the control register next to the run-enable bit. After the counter is moved or the alarm is changed, software rewrites the alarm and the periods. The next alarm then realigns every channel. The number of channels is a build parameter, either two or three.

Top module: `alarm_pulse_gen`

## Requirements
- R1: After reset all pulse outputs and the alarm event are low, and the alarm is disarmed. No event occurs until an alarm word is written, whatever the counter value.
- R2: While the alarm is armed, a tick cycle (tc_tick high) in which tc_value, read as unsigned 64 bits, is equal to or above the alarm makes alarm_evt_o high for exactly the following clock cycle.
- R3: The alarm fires only once. It stays silent while the counter remains past it, and it arms again only when address 0 (alarm low word) or address 1 (alarm high word) is written.
- R4: With step S taken from control bits [15:8] and period register P_i at address 4+i, channel i pulses in the cycle after the first tick that follows the alarm. It then pulses every (P_i+S)/S ticks, and each pulse lasts one clock cycle.
- R5: No pulse output is high except in the cycle right after a tick cycle.
- R6: Writing address 2 with bit 0 clear stops all channels, and their outputs are low from the second cycle after the write onward. Setting bit 0 again does not restart them until the next alarm fires.
- R7: If the alarm fires while control bit 0 is clear, the event is still raised, but no channel starts.
- R8: If the alarm fires on a tick where a running channel was due to pulse, that pulse is dropped and every channel restarts its phase from that alarm.
- R9: The alarm compare covers the full 64 bits. A low alarm word below the counter's low word does not fire while the counter's high word is still below the alarm's high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_value | input | 64 | Current time counter value in ns |
| tc_tick | input | 1 | High in cycles where the time counter advances |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 alarm low, 1 alarm high, 2 control, 4+i period of channel i |
| wr_data | input | 32 | Register write data |
| pulse_o | output | NUM_CH | One-clock pulse per channel |
| alarm_evt_o | output | 1 | One-clock alarm event |

## Verification
The alarm compare and a channel's reload can fall on the same tick. This happens when software rewrites the alarm while the channels are running. The bench provokes it by working out the tick at which channel 0 is next due to pulse and placing the new alarm exactly on that counter value. At that tick it expects the event and no pulse. After that it expects every channel to keep the new phase, counted from the alarm tick.

// File: rtl/alarm_pulse_gen.sv
module alarm_pulse_gen #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       tc_value,
  input  logic              tc_tick,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic [NUM_CH-1:0] pulse_o,
  output logic              alarm_evt_o
);
  localparam int TW = 64;
  localparam int PW = 32;
  localparam int SW = 8;

  logic [TW-1:0] alarm_q;
  logic [SW-1:0] step_q;
  logic          armed_q, en_q, run_q;
  logic          wr_alarm, wr_ctrl, fire;
  logic [PW-1:0] step_ext;
  logic          unused_ctrl_bits;

  assign wr_alarm = wr_en && (wr_addr[2:1] == 2'b00);
  assign wr_ctrl  = wr_en && (wr_addr == 3'd2);
  assign fire     = tc_tick && armed_q && (tc_value >= alarm_q);
  assign step_ext = {{(PW-SW){1'b0}}, step_q};
  assign unused_ctrl_bits = ^{wr_data[31:16], wr_data[7:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q <= '0;
      armed_q <= 1'b0;
    end else if (wr_alarm) begin
      if (wr_addr[0]) alarm_q[63:32] <= wr_data;
      else            alarm_q[31:0]  <= wr_data;
      armed_q <= 1'b1;
    end else if (fire) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      step_q <= '0;
    end else if (wr_ctrl) begin
      en_q   <= wr_data[0];
      step_q <= wr_data[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     run_q <= 1'b0;
    else if (!en_q) run_q <= 1'b0;
    else if (fire)  run_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) alarm_evt_o <= 1'b0;
    else        alarm_evt_o <= fire;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [PW-1:0] per_q, cnt_q;
    logic          pul_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                                  per_q <= '0;
      else if (wr_en && (wr_addr == 3'(4 + i)))    per_q <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q <= '0;
        pul_q <= 1'b0;
      end else if (!en_q) begin
        pul_q <= 1'b0;
      end else if (fire) begin
        cnt_q <= '0;
        pul_q <= 1'b0;
      end else if (run_q && tc_tick) begin
        if (cnt_q < step_ext) begin
          pul_q <= 1'b1;
          cnt_q <= per_q;
        end else begin
          pul_q <= 1'b0;
          cnt_q <= cnt_q - step_ext;
        end
      end else begin
        pul_q <= 1'b0;
      end
    end

    assign pulse_o[i] = pul_q;
  end
endmodule

// File: rtl/alarm_pulse_gen_chk.sv
module alarm_pulse_gen_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tc_tick,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [31:0]       wr_data,
  input logic [NUM_CH-1:0] pulse_o,
  input logic              alarm_evt_o
);
  logic alarm_wr, stop_wr, unused_data;
  assign alarm_wr    = wr_en && (wr_addr[2:1] == 2'b00);
  assign stop_wr     = wr_en && (wr_addr == 3'd2) && !wr_data[0];
  assign unused_data = ^wr_data[31:1];

  AST_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt_o |-> $past(tc_tick)); // R2
  AST_EVT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_evt_o && !$past(alarm_wr)) |=> !alarm_evt_o); // R3
  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o != '0) |-> $past(tc_tick)); // R5
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> ##1 (pulse_o == '0)); // R6
  AST_FIRE_DROPS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt_o |-> (pulse_o == '0)); // R8
endmodule

bind alarm_pulse_gen alarm_pulse_gen_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/tb_alarm_pulse_gen.sv
module tb_alarm_pulse_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tc_value = '0;
  logic        tc_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  pulse_o;
  logic        alarm_evt_o;

  alarm_pulse_gen #(.NUM_CH(3)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [63:0] tv = '0, alarm_m = '0;
  bit armed_m = 0, en_m = 0, run_m = 0;
  int s_m = 0, n = 0, last_fire = -1;
  int dper [3];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic cyc(input bit t, input string tag);
    bit f;
    logic [2:0] ep;
    f = t && armed_m && (tv >= alarm_m);
    tc_tick = t;
    @(posedge clk); #1;
    tc_tick = 1'b0;
    if (f) begin
      armed_m = 0;
      if (en_m) begin run_m = 1; last_fire = n; end
    end
    ep = '0;
    if (t && run_m && !f)
      for (int i = 0; i < 3; i++)
        if (n > last_fire && ((n - last_fire - 1) % (dper[i] / s_m)) == 0) ep[i] = 1'b1;
    chk("R2,R3 event", 64'(alarm_evt_o), 64'(f));
    chk(tag, 64'(pulse_o), 64'(ep));
    if (t) begin n++; tv += 64'(s_m); end
    tc_value = tv;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R5 write cycle", {62'b0, alarm_evt_o, |pulse_o}, 64'd0);
    if (a == 3'd0) begin alarm_m[31:0] = d; armed_m = 1; end
    if (a == 3'd1) begin alarm_m[63:32] = d; armed_m = 1; end
    if (a == 3'd2) begin
      en_m = d[0]; s_m = int'(d[15:8]);
      if (!en_m) run_m = 0;
    end
  endtask

  task automatic set_alarm(input logic [63:0] v);
    wr(3'd0, v[31:0]);
    wr(3'd1, v[63:32]);
  endtask

  task automatic cfg(input bit en, input int s);
    wr(3'd2, {16'h0, 8'(s), 7'h0, en});
  endtask

  task automatic run(input int ticks, input bit gap, input string tag);
    for (int k = 0; k < ticks; k++) begin
      cyc(1'b1, tag);
      if (gap) cyc(1'b0, "R5 idle cycle");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    wrap_up();
  end

  initial begin
    dper[0] = 1; dper[1] = 1; dper[2] = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pulses", 64'(pulse_o), 64'd0);
    chk("R1 reset event", 64'(alarm_evt_o), 64'd0);
    rst_n = 1'b1;
    tv = 64'h100; tc_value = tv; s_m = 1;
    run(5, 1'b0, "R1 disarmed");

    for (int si = 0; si < 3; si++) begin
      for (int g = 0; g < 2; g++) begin
        int s, q0, m;
        s = 1 << si;
        cfg(1'b0, s);
        dper[0] = s * (2 + g); dper[1] = s * (3 + si); dper[2] = s * 7;
        for (int i = 0; i < 3; i++) wr(3'(4 + i), 32'(dper[i] - s));
        cfg(1'b1, s);
        tv = 64'h0000_0001_FFFF_FFF0; tc_value = tv;
        // R9: alarm low word lands below the counter's low word, high word above
        set_alarm(tv + 64'(20 * s));
        run(45, g[0], "R4 pulse train");

        q0 = dper[0] / s;
        m = 2;
        while (((n + m - last_fire - 1) % q0) != 0) m++;
        set_alarm(tv + 64'(m * s));
        run(25, g[0], "R8 collision and realign");

        cfg(1'b0, s);
        run(8, g[0], "R6 stopped");
        cfg(1'b1, s);
        run(8, g[0], "R6 re-enabled without alarm");

        cfg(1'b0, s);
        set_alarm(tv + 64'(3 * s));
        run(8, g[0], "R7 alarm while disabled");
      end
    end
    wrap_up();
  end
endmodule